// File: doc/BRIEF.md
# Two-Register Serial Port

A byte-wide serial port for an 8-bit processor bus. Software sees two locations: a data location that transmits on write and returns the last received byte on read, and a read-only status location. All line timing is fixed when the design is built. The clock frequency and the baud rate are parameters, and the bit period is their quotient. There is no runtime setup, and no hardware flow control. Pacing is left to software, which polls the status flags or services the interrupt.

The transmitter sends one frame at a time: a start bit, eight data bits least significant first, and one stop bit, with no parity. The receiver synchronizes the line through two flops and waits for a falling edge. It confirms the start bit half a bit later, then samples each bit at its centre. A received byte sets a receive-full flag and raises the interrupt line. Reading status drops the interrupt, and reading data drops the receive-full flag.

Top module: `uart_lite`

## Requirements
- R1: After reset, tx_o is high, irq_o is low and STATUS reads 0x10.
- R2: Address bit 0 selects DATA and 1 selects STATUS. STATUS bit 3 is receive full, bit 4 is transmitter empty, bit 7 is interrupt pending, and the other bits read 0. rdata_o is 0 while cs_i is low.
- R3: A DATA write while the transmitter is empty sends a frame starting on the next cycle: start bit 0, data bits LSB first, stop bit 1.
- R4: STATUS bit 4 clears at the accepting write and returns 10 bit periods later. A DATA write made while the transmitter is busy is dropped.
- R5: A write to STATUS changes nothing: no frame is sent and STATUS keeps its value.
- R6: A valid received frame stores its byte in DATA, sets receive full and asserts irq_o.
- R7: A STATUS read clears the interrupt pending flag and irq_o, and leaves receive full unchanged.
- R8: A DATA read clears receive full and leaves the interrupt pending flag unchanged.
- R9: A byte received while receive full is still set overwrites the stored byte.
- R10: A frame whose stop bit samples low is discarded: no flag changes and no interrupt.
- R11: A low pulse that has ended by the half-bit check is not taken as a start bit.
- R12: With the default parameters (50 MHz clock, 115200 baud), each bit lasts 434 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| addr_i | input | 1 | Register select: 0 data, 1 status |
| we_i | input | 1 | Write strobe, one cycle per access |
| re_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request, active high |
| tx_o | output | 1 | Serial transmit line, idle high |
| rx_i | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions assume that each bus access holds its strobe for exactly one cycle and never raises read and write together. They also assume that rx_i keeps every level for at least one bit period, apart from a deliberate short glitch. The bench drives the bus on falling clock edges with single-cycle strobes. It shapes every serial frame from whole bit periods counted in clock cycles, and it issues the glitch only while the receiver is idle.

// File: rtl/uart_lite_pkg.sv
package uart_lite_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = DATA_W + 2;

  localparam int unsigned ST_RX_FULL  = 3;
  localparam int unsigned ST_TX_EMPTY = 4;
  localparam int unsigned ST_IRQ      = 7;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_lite_tx.sv
module uart_lite_tx
  import uart_lite_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 434
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      cnt_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        shreg_q <= {1'b1, data_i, 1'b0};
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        idx_q   <= '0;
      end
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
      if (idx_q == IDX_LAST) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tx_o   = busy_q ? shreg_q[0] : 1'b1;
  assign busy_o = busy_q;

  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !tx_o);
  p_stop_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(tx_o));
  p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && load_i && idx_q != IDX_LAST) |=> busy_q);
endmodule

// File: rtl/uart_lite_rx.sv
module uart_lite_rx
  import uart_lite_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 434
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic rx_meta_q, rx_sync_q, rx_prev_q;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_meta_q <= 1'b1;
      rx_sync_q <= 1'b1;
      rx_prev_q <= 1'b1;
    end else begin
      rx_meta_q <= rx_i;
      rx_sync_q <= rx_meta_q;
      rx_prev_q <= rx_sync_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (rx_prev_q && !rx_sync_q) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rx_sync_q ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            shreg_q <= {rx_sync_q, shreg_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) state_q <= RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            valid_q <= rx_sync_q;
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign data_o  = shreg_q;

  p_stop_checked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(rx_sync_q));
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/uart_lite.sv
module uart_lite
  import uart_lite_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 115_200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       addr_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       tx_o,
  input  logic       rx_i
);
  localparam int unsigned CLKS_PER_BIT = CLK_HZ / BAUD;

  logic              tx_busy, tx_load;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] data_q;
  logic              rx_full_q, irq_q;
  logic              rd_data, rd_stat, wr_stat;
  logic [7:0]        status;

  assign tx_load = cs_i && we_i && !addr_i;
  assign wr_stat = cs_i && we_i && addr_i;
  assign rd_data = cs_i && re_i && !addr_i;
  assign rd_stat = cs_i && re_i && addr_i;

  uart_lite_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (wdata_i),
    .tx_o   (tx_o),
    .busy_o (tx_busy)
  );

  uart_lite_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .valid_o (rx_valid),
    .data_o  (rx_byte)
  );

  // a new byte wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      rx_full_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (rx_valid) begin
      data_q    <= rx_byte;
      rx_full_q <= 1'b1;
      irq_q     <= 1'b1;
    end else begin
      if (rd_data) rx_full_q <= 1'b0;
      if (rd_stat) irq_q     <= 1'b0;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_RX_FULL]  = rx_full_q;
    status[ST_TX_EMPTY] = !tx_busy;
    status[ST_IRQ]      = irq_q;
  end

  assign rdata_o = !cs_i ? 8'h00 : (addr_i ? status : data_q);
  assign irq_o   = irq_q;

  p_rx_sets_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |=> (irq_q && rx_full_q && data_q == $past(rx_byte)));
  p_stat_read_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !rx_valid) |=> (!irq_o && rx_full_q == $past(rx_full_q)));
  p_data_read_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_valid) |=> (!rx_full_q && irq_q == $past(irq_q)));
  p_stat_write_inert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !tx_busy) |=> (!tx_busy && tx_o));
  p_rw_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i && re_i));
endmodule

// File: tb/uart_lite_tb.sv
module uart_lite_tb;
  localparam int CLKS = 50_000_000 / 115_200;  // 434
  localparam logic [7:0] ST_FULL = 8'h08, ST_EMPTY = 8'h10, ST_IRQ = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, addr = 0, we = 0, re = 0, rx = 1;
  logic [7:0] wdata = 0, rdata;
  logic irq, tx;

  int checks = 0, errors = 0, frames = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  uart_lite u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .addr_i(addr), .we_i(we),
    .re_i(re), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .tx_o(tx), .rx_i(rx)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic bus_read(logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; re = 0;
  endtask

  task automatic send_byte(logic [7:0] d);
    exp_q.push_back(d);
    bus_write(1'b0, d);
  endtask

  task automatic drive_rx(logic [7:0] d, logic stop);
    @(negedge clk); rx = 0;
    repeat (CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (CLKS) @(negedge clk);
    end
    rx = stop;
    repeat (CLKS) @(negedge clk);
    rx = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_frame();
    repeat (10 * CLKS + 20) @(negedge clk);
  endtask

  // monitor: decode tx at bit centres, compare with scoreboard
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge tx);
      repeat (CLKS / 2) @(posedge clk);
      chk("R3 start bit", {7'b0, tx}, 8'h00);
      for (int i = 0; i < 8; i++) begin
        repeat (CLKS) @(posedge clk);
        got[i] = tx;
      end
      repeat (CLKS) @(posedge clk);
      chk("R3 stop bit", {7'b0, tx}, 8'h01);
      frames++;
      if (exp_q.size() == 0) begin
        chk("R4 unexpected frame", got, 8'hxx);
      end else begin
        chk("R3 frame data", got, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 tx idle", {7'b0, tx}, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    bus_read(1'b1, d); chk("R1 status", d, ST_EMPTY);
    #1 chk("R2 rdata without cs", rdata, 8'h00);

    // R3 frames with several patterns
    send_byte(8'hA5); wait_frame();
    send_byte(8'h3C); wait_frame();
    send_byte(8'h00); wait_frame();
    send_byte(8'hFF); wait_frame();

    // R4 busy window
    send_byte(8'h81);
    repeat (10 * CLKS - 3) @(negedge clk);
    bus_read(1'b1, d); chk("R4 busy near end", d & ST_EMPTY, 8'h00);
    repeat (2) @(negedge clk);
    bus_read(1'b1, d); chk("R4 empty after frame", d & ST_EMPTY, ST_EMPTY);
    repeat (20) @(negedge clk);

    // R4 write while busy is dropped
    send_byte(8'h5A);
    repeat (100) @(negedge clk);
    bus_write(1'b0, 8'hC3);
    wait_frame(); wait_frame();

    // R12 bit period: 0xFE keeps the line low for start + bit0
    exp_q.push_back(8'hFE);
    bus_write(1'b0, 8'hFE);
    cnt = 0;
    while (tx == 1'b0) begin cnt++; @(negedge clk); end
    chk("R12 two bit periods low", 8'(cnt / 4), 8'(2 * CLKS / 4));
    checks++;
    if (cnt != 2 * CLKS) begin
      errors++;
      $display("FAIL R12 low cycles actual=%0d expected=%0d", cnt, 2 * CLKS);
    end
    wait_frame();

    // R5 write to status is inert
    bus_write(1'b1, 8'h55);
    repeat (5) @(negedge clk);
    chk("R5 tx idle", {7'b0, tx}, 8'h01);
    bus_read(1'b1, d); chk("R5 status", d, ST_EMPTY);
    wait_frame();
    chk("R4 R5 frame count", 8'(frames), 8'd7);
    chk("R4 scoreboard empty", 8'(exp_q.size()), 8'd0);

    // R6 receive
    drive_rx(8'h6E, 1'b1);
    chk("R6 irq", {7'b0, irq}, 8'h01);
    bus_read(1'b1, d); chk("R6 status", d, ST_IRQ | ST_EMPTY | ST_FULL);
    bus_read(1'b1, d); chk("R7 status after read", d, ST_EMPTY | ST_FULL);
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
    bus_read(1'b0, d); chk("R6 data", d, 8'h6E);
    bus_read(1'b1, d); chk("R8 full cleared", d, ST_EMPTY);

    // R8 data read leaves irq
    drive_rx(8'h11, 1'b1);
    bus_read(1'b0, d); chk("R8 data", d, 8'h11);
    chk("R8 irq kept", {7'b0, irq}, 8'h01);
    bus_read(1'b1, d); chk("R8 status", d, ST_IRQ | ST_EMPTY);
    bus_read(1'b1, d); chk("R7 cleared", d, ST_EMPTY);

    // R9 overwrite
    drive_rx(8'h22, 1'b1);
    drive_rx(8'h33, 1'b1);
    bus_read(1'b0, d); chk("R9 newest byte", d, 8'h33);
    bus_read(1'b1, d);

    // R10 bad stop bit
    drive_rx(8'h44, 1'b0);
    repeat (CLKS) @(negedge clk);
    chk("R10 no irq", {7'b0, irq}, 8'h00);
    bus_read(1'b1, d); chk("R10 status", d, ST_EMPTY);
    bus_read(1'b0, d); chk("R10 data kept", d, 8'h33);
    drive_rx(8'h55, 1'b1);
    bus_read(1'b0, d); chk("R10 recovers", d, 8'h55);
    bus_read(1'b1, d);

    // R11 short glitch
    @(negedge clk); rx = 0;
    repeat (100) @(negedge clk);
    rx = 1;
    repeat (12 * CLKS) @(negedge clk);
    chk("R11 no irq", {7'b0, irq}, 8'h00);
    bus_read(1'b1, d); chk("R11 status", d, ST_EMPTY);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule